// File: doc/BRIEF.md
# Branch History Recorder

The block keeps a circular history of the most recent taken branches retired by a core. Each branch arrives on a single-cycle valid strobe. It carries a source address, a target address, the privilege ring of its target, a kind code and a mispredict bit. A suppress-polarity select register discards unwanted branch kinds and rings before anything is stored. Each surviving branch is written one slot past the current top-of-stack pointer, and the pointer then moves to that slot.

Software uses a plain register port with a write strobe, a 12-bit address and a combinational read. Through it, software sets the controls and the select mask, reads the pointer, and reads any slot by index. To walk the history from newest to oldest, software reads slot `(top - i) & (DEPTH-1)` for increasing `i`.

A performance-monitor interrupt pulse can freeze the history so that it stays consistent while the interrupt handler reads it. A clear command zeroes every slot and the pointer.

Top module: `lbr_stack`

## Requirements
- R1: After synchronous active-low reset, the following all read zero: the control word (address 0x000), the select word (address 0x001), the pointer (address 0x002), every source slot (address 0x100+i) and every target slot (address 0x200+i).
- R2: A recorded branch is written to slot (pointer+1) & (DEPTH-1), and the pointer takes that value at the same clock edge. It wraps from DEPTH-1 to 0.
- R3: The select word holds 9 bits. A write keeps bits 8:0, and bits above bit 8 always read zero.
- R4: Kind codes map to select bits as follows: 0 conditional → bit 2, 1 relative call → bit 3, 2 indirect call → bit 4, 3 near return → bit 5, 4 indirect jump → bit 6, 5 relative jump → bit 7, 6 far branch → bit 8. When the selected bit is set, the branch is dropped, and kind 7 is always dropped. A dropped branch changes neither the pointer nor any slot.
- R5: The ring filter uses the target ring input (0 = ring 0, 1 = ring above 0). Select bit 0 drops branches whose target is ring 0, and select bit 1 drops branches whose target is above ring 0.
- R6: A source slot stores the mispredict flag in bit 63 and source address bits 62:0 in bits 62:0. A target slot stores the whole target address.
- R7: Control bit 0 enables recording. While it is 0, no branch is recorded.
- R8: When control bit 1 (freeze enable) is set, an interrupt pulse sets the frozen flag, which reads back as control bit 2. A branch in the same cycle as the pulse is not recorded, and while the flag is set the pointer and all slots hold their values.
- R9: Only a control write with bit 2 equal to 0 clears the frozen flag. A control write with bit 2 equal to 1 leaves it set. An interrupt pulse in the same cycle as a releasing write keeps the block frozen.
- R10: A control write with bit 3 set zeroes every slot and the pointer, and this takes priority over a branch in the same cycle. Bit 3 always reads zero.
- R11: A slot read at an index of DEPTH or above, and a read at any unmapped address, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A taken branch retires this cycle |
| br_src | input | AW | Branch source address |
| br_dst | input | AW | Branch target address |
| br_tgt_ring | input | 1 | Target ring: 0 = ring 0, 1 = above ring 0 |
| br_kind | input | 3 | Branch kind code (see R4) |
| br_mispred | input | 1 | Branch was mispredicted |
| pmi_pulse | input | 1 | Performance-monitor interrupt pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Combinational register read data |

## Verification
Three pairs of events can land on the same clock edge, and each is provoked on purpose:
- An interrupt pulse with a retiring branch. The branch must be lost and the pointer must not move.
- A clear command with a retiring branch. Every slot and the pointer must read zero afterwards.
- A releasing control write with an interrupt pulse. The frozen flag must stay set.

Random traffic also puts interrupt pulses, select rewrites and control writes next to the branch stream. A bench model, which applies the requirements to the state before each edge, judges the full register contents at regular intervals.

// File: rtl/lbr_pkg.sv
// Shared definitions for the branch history recorder.
// Assumes a 12-bit register address split into a 4-bit group and an 8-bit offset.
package lbr_pkg;
    typedef enum logic [2:0] {
        K_COND    = 3'd0,
        K_RELCALL = 3'd1,
        K_INDCALL = 3'd2,
        K_NEARRET = 3'd3,
        K_INDJMP  = 3'd4,
        K_RELJMP  = 3'd5,
        K_FAR     = 3'd6,
        K_RSVD    = 3'd7
    } br_kind_e;

    localparam int SEL_W     = 9;
    localparam int GRP_CFG   = 0;
    localparam int GRP_SRC   = 1;
    localparam int GRP_DST   = 2;
    localparam int OFF_CTL   = 0;
    localparam int OFF_SEL   = 1;
    localparam int OFF_TOP   = 2;
    localparam int CTL_EN    = 0;
    localparam int CTL_FRZEN = 1;
    localparam int CTL_FROZE = 2;
    localparam int CTL_CLR   = 3;
endpackage

// File: rtl/lbr_filter.sv
// Suppress-polarity branch filter: decides whether a branch is dropped.
// Assumes the ring tag describes the branch target, not the source.
module lbr_filter
    import lbr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             tgt_ring,
    input  logic [2:0]       kind,
    output logic             drop
);
    logic ring_drop;
    logic kind_drop;

    // Ring suppression by target privilege
    always_comb ring_drop = tgt_ring ? sel[1] : sel[0];

    // Kind suppression; the reserved code never survives
    always_comb begin
        case (br_kind_e'(kind))
            K_COND:    kind_drop = sel[2];
            K_RELCALL: kind_drop = sel[3];
            K_INDCALL: kind_drop = sel[4];
            K_NEARRET: kind_drop = sel[5];
            K_INDJMP:  kind_drop = sel[6];
            K_RELJMP:  kind_drop = sel[7];
            K_FAR:     kind_drop = sel[8];
            default:   kind_drop = 1'b1;
        endcase
    end

    // Combined decision
    always_comb drop = ring_drop | kind_drop;
endmodule

// File: rtl/lbr_ctrl.sv
// Control state: record enable, freeze enable, frozen flag and select mask.
// Assumes the clear command is a one-cycle strobe decoded from a control write.
module lbr_ctrl
    import lbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_sel,
    input  logic [SEL_W-1:0] wdata,
    input  logic             pmi_pulse,
    output logic             rec_en,
    output logic             frz_en,
    output logic             frozen,
    output logic [SEL_W-1:0] sel,
    output logic             clr,
    output logic             hold
);
    logic freeze_hit;

    // Interrupt takes effect only when freezing is armed
    always_comb freeze_hit = pmi_pulse & frz_en;

    // Block writes in this cycle if already frozen or freezing now
    always_comb hold = frozen | freeze_hit;

    // Clear strobe from a control write
    always_comb clr = wr_ctl & wdata[CTL_CLR];

    // Enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_en <= 1'b0;
            frz_en <= 1'b0;
        end else if (wr_ctl) begin
            rec_en <= wdata[CTL_EN];
            frz_en <= wdata[CTL_FRZEN];
        end
    end

    // Frozen flag: set by interrupt, released only by a write with bit 2 low
    always_ff @(posedge clk) begin
        if (!rst_n)                             frozen <= 1'b0;
        else if (freeze_hit)                    frozen <= 1'b1;
        else if (wr_ctl && !wdata[CTL_FROZE])   frozen <= 1'b0;
    end

    // Select mask
    always_ff @(posedge clk) begin
        if (!rst_n)      sel <= '0;
        else if (wr_sel) sel <= wdata;
    end

    AST_FREEZE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (pmi_pulse && frz_en) |=> frozen); // R8
    AST_FREEZE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !(wr_ctl && !wdata[CTL_FROZE])) |=> frozen); // R9
endmodule

// File: rtl/lbr_store.sv
// Circular slot storage with a top-of-stack pointer.
// Assumes DEPTH is a power of two; a clear has priority over a write.
module lbr_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 64,
    parameter int IW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     clr,
    input  logic [AW-1:0]            src_word,
    input  logic [AW-1:0]            dst_word,
    input  logic [IW-1:0]            rd_idx,
    output logic [$clog2(DEPTH)-1:0] tos,
    output logic [AW-1:0]            rd_src,
    output logic [AW-1:0]            rd_dst
);
    localparam int TW = $clog2(DEPTH);

    logic [AW-1:0] src_mem [DEPTH];
    logic [AW-1:0] dst_mem [DEPTH];
    logic [TW-1:0] tos_q;
    logic [TW-1:0] nxt;
    logic          in_range;

    // Next write slot
    always_comb nxt = tos_q + TW'(1);

    // Pointer update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) tos_q <= '0;
        else if (wr_en)    tos_q <= nxt;
    end

    // Slot storage, one pair per entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                src_mem[g] <= '0;
                dst_mem[g] <= '0;
            end else if (wr_en && nxt == TW'(g)) begin
                src_mem[g] <= src_word;
                dst_mem[g] <= dst_word;
            end
        end
    end

    // Indexed read, zero outside the stack
    always_comb begin
        in_range = 32'(rd_idx) < DEPTH;
        rd_src   = in_range ? src_mem[rd_idx[TW-1:0]] : '0;
        rd_dst   = in_range ? dst_mem[rd_idx[TW-1:0]] : '0;
    end

    always_comb tos = tos_q;

    AST_TOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> tos_q == $past(tos_q) + TW'(1)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(tos_q)); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tos_q == '0 && src_mem[0] == '0 && dst_mem[DEPTH-1] == '0)); // R10
endmodule

// File: rtl/lbr_stack.sv
// Top of the branch history recorder: filter, control, storage and register decode.
// Assumes AW > SEL_W and a 12-bit address of {group[3:0], offset[7:0]}.
module lbr_stack
    import lbr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_valid,
    input  logic [AW-1:0] br_src,
    input  logic [AW-1:0] br_dst,
    input  logic          br_tgt_ring,
    input  logic [2:0]    br_kind,
    input  logic          br_mispred,
    input  logic          pmi_pulse,
    input  logic          reg_we,
    input  logic [11:0]   reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata
);
    localparam int TW = $clog2(DEPTH);
    localparam int IW = 8;

    logic [3:0]       grp;
    logic [IW-1:0]    off;
    logic             wr_ctl, wr_sel;
    logic             rec_en, frz_en, frozen, clr, hold, drop, wr_en;
    logic [SEL_W-1:0] sel;
    logic [TW-1:0]    tos;
    logic [AW-1:0]    rd_src, rd_dst, src_word;

    // Address split
    always_comb begin
        grp = reg_addr[11:8];
        off = reg_addr[7:0];
    end

    // Write decode
    always_comb begin
        wr_ctl = reg_we && grp == 4'(GRP_CFG) && off == IW'(OFF_CTL);
        wr_sel = reg_we && grp == 4'(GRP_CFG) && off == IW'(OFF_SEL);
    end

    lbr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_ctl),
        .wr_sel    (wr_sel),
        .wdata     (reg_wdata[SEL_W-1:0]),
        .pmi_pulse (pmi_pulse),
        .rec_en    (rec_en),
        .frz_en    (frz_en),
        .frozen    (frozen),
        .sel       (sel),
        .clr       (clr),
        .hold      (hold)
    );

    lbr_filter u_filter (
        .sel      (sel),
        .tgt_ring (br_tgt_ring),
        .kind     (br_kind),
        .drop     (drop)
    );

    // Pack mispredict flag above the address and gate the write
    always_comb begin
        src_word = {br_mispred, br_src[AW-2:0]};
        wr_en    = br_valid && rec_en && !hold && !drop && !clr;
    end

    lbr_store #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .clr      (clr),
        .src_word (src_word),
        .dst_word (br_dst),
        .rd_idx   (off),
        .tos      (tos),
        .rd_src   (rd_src),
        .rd_dst   (rd_dst)
    );

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (grp)
            4'(GRP_CFG): begin
                if (off == IW'(OFF_CTL))      reg_rdata = AW'({frozen, frz_en, rec_en});
                else if (off == IW'(OFF_SEL)) reg_rdata = AW'(sel);
                else if (off == IW'(OFF_TOP)) reg_rdata = AW'(tos);
            end
            4'(GRP_SRC): reg_rdata = rd_src;
            4'(GRP_DST): reg_rdata = rd_dst;
            default:     reg_rdata = '0;
        endcase
    end

    AST_DROP_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && drop && !clr) |=> $stable(tos)); // R4
    AST_DISABLED_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_en && !clr) |=> $stable(tos)); // R7
    AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == 4'(GRP_CFG) && off == IW'(OFF_SEL)) |-> reg_rdata[AW-1:SEL_W] == '0); // R3
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp == 4'(GRP_SRC) || grp == 4'(GRP_DST)) && 32'(off) >= DEPTH) |-> reg_rdata == '0); // R11
endmodule

// File: tb/tb_lbr_stack.sv
// Self-checking bench: directed corners plus seeded random traffic against a model.
module tb_lbr_stack;
    localparam int DEPTH = 16;
    localparam int AW    = 64;
    localparam logic [11:0] A_CTL = 12'h000, A_SEL = 12'h001, A_TOP = 12'h002;
    localparam logic [11:0] A_SRC = 12'h100, A_DST = 12'h200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_valid = 1'b0;
    logic [AW-1:0] br_src = '0, br_dst = '0;
    logic          br_tgt_ring = 1'b0;
    logic [2:0]    br_kind = '0;
    logic          br_mispred = 1'b0;
    logic          pmi_pulse = 1'b0;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [AW-1:0] m_src [DEPTH];
    logic [AW-1:0] m_dst [DEPTH];
    int            m_tos;
    logic          m_en, m_frz, m_frozen;
    logic [8:0]    m_sel;

    always #2 clk = ~clk;

    lbr_stack #(.DEPTH(DEPTH), .AW(AW)) dut (.*);

    function automatic logic model_drop(input logic [8:0] s, input logic ring, input logic [2:0] k);
        logic r;
        r = ring ? s[1] : s[0];
        if (k == 3'd7) return 1'b1;
        return r | s[2 + int'(k)];
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin m_src[i] = '0; m_dst[i] = '0; end
        m_tos = 0; m_en = 0; m_frz = 0; m_frozen = 0; m_sel = '0;
    endtask

    // One cycle of stimulus; model advances from pre-edge state
    task automatic step(input logic v, input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input logic ring, input logic [2:0] k, input logic mp,
                        input logic p, input logic we, input logic [11:0] a,
                        input logic [AW-1:0] wd);
        logic hold, clrp, wctl;
        br_valid = v; br_src = s; br_dst = d; br_tgt_ring = ring; br_kind = k;
        br_mispred = mp; pmi_pulse = p; reg_we = we; reg_addr = a; reg_wdata = wd;
        wctl = we && a == A_CTL;
        hold = m_frozen | (p & m_frz);
        clrp = wctl && wd[3];
        if (clrp) begin
            for (int i = 0; i < DEPTH; i++) begin m_src[i] = '0; m_dst[i] = '0; end
            m_tos = 0;
        end else if (v && m_en && !hold && !model_drop(m_sel, ring, k)) begin
            m_tos = (m_tos + 1) % DEPTH;
            m_src[m_tos] = {mp, s[AW-2:0]};
            m_dst[m_tos] = d;
        end
        if (p && m_frz)             m_frozen = 1'b1;
        else if (wctl && !wd[2])    m_frozen = 1'b0;
        if (wctl) begin m_en = wd[0]; m_frz = wd[1]; end
        if (we && a == A_SEL) m_sel = wd[8:0];
        @(posedge clk);
        @(negedge clk);
        br_valid = 1'b0; pmi_pulse = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [AW-1:0] wd);
        step(1'b0, '0, '0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, a, wd);
    endtask

    task automatic br(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic ring,
                      input logic [2:0] k, input logic mp);
        step(1'b1, s, d, ring, k, mp, 1'b0, 1'b0, 12'h000, '0);
    endtask

    task automatic rd(input logic [11:0] a, output logic [AW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [AW-1:0] d;
        rd(A_CTL, d); chk({tag, " R8 ctl"}, d, AW'({m_frozen, m_frz, m_en}));
        rd(A_SEL, d); chk({tag, " R3 sel"}, d, AW'(m_sel));
        rd(A_TOP, d); chk({tag, " R2 top"}, d, AW'(m_tos));
        for (int i = 0; i < DEPTH; i++) begin
            rd(A_SRC + 12'(i), d); chk({tag, " R6 src"}, d, m_src[i]);
            rd(A_DST + 12'(i), d); chk({tag, " R6 dst"}, d, m_dst[i]);
        end
        rd(A_SRC + 12'(DEPTH), d); chk({tag, " R11 oor src"}, d, '0);
        rd(A_DST + 12'hFF, d);     chk({tag, " R11 oor dst"}, d, '0);
        rd(12'h7A5, d);            chk({tag, " R11 unmapped"}, d, '0);
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] d;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R3: upper select bits read zero
        wr(A_SEL, '1);
        rd(A_SEL, d); chk("R3 sel mask", d, 64'h1FF);
        wr(A_SEL, '0);

        // R7: disabled, nothing recorded
        br(64'h1111, 64'h2222, 1'b1, 3'd0, 1'b0);
        rd(A_TOP, d); chk("R7 disabled top", d, 0);

        // R2/R6: enabled record with mispredict
        wr(A_CTL, 64'h1);
        br(64'hFFFF_0000_1234_5678, 64'h8000_0000_0000_0ABC, 1'b1, 3'd1, 1'b1);
        rd(A_TOP, d); chk("R2 first top", d, 1);
        rd(A_SRC + 12'd1, d); chk("R6 packed src", d, 64'hFFFF_0000_1234_5678);
        br(64'hFFFF_0000_1234_5678, 64'h5, 1'b1, 3'd1, 1'b0);
        rd(A_SRC + 12'd2, d); chk("R6 flag clear", d, 64'h7FFF_0000_1234_5678);

        // R4: drop conditional kind and reserved kind
        wr(A_SEL, 64'h4);
        br(64'h33, 64'h44, 1'b1, 3'd0, 1'b0);
        br(64'h35, 64'h46, 1'b1, 3'd7, 1'b0);
        rd(A_TOP, d); chk("R4 drop top", d, 2);

        // R5: drop by target ring 0
        wr(A_SEL, 64'h1);
        br(64'h55, 64'h66, 1'b0, 3'd2, 1'b0);
        rd(A_TOP, d); chk("R5 ring0 dropped", d, 2);
        br(64'h55, 64'h66, 1'b1, 3'd2, 1'b0);
        rd(A_TOP, d); chk("R5 ring3 kept", d, 3);
        wr(A_SEL, '0);

        // R2: wraparound
        for (int i = 0; i < DEPTH + 3; i++) br(rnd64(), rnd64(), 1'b1, 3'd5, 1'b0);
        check_all("R2 wrap");

        // R8: interrupt and branch in the same cycle
        wr(A_CTL, 64'h3);
        step(1'b1, 64'hAA, 64'hBB, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0, 12'h0, '0);
        rd(A_TOP, d); chk("R8 same-cycle top", d, AW'(m_tos));
        rd(A_CTL, d); chk("R8 frozen flag", d, 64'h7);
        br(64'hCC, 64'hDD, 1'b1, 3'd3, 1'b0);
        check_all("R8 frozen hold");

        // R9: write with bit 2 set keeps frozen; release races interrupt
        wr(A_CTL, 64'h7);
        rd(A_CTL, d); chk("R9 keep frozen", d, 64'h7);
        step(1'b0, '0, '0, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, A_CTL, 64'h3);
        rd(A_CTL, d); chk("R9 pmi wins", d, 64'h7);
        wr(A_CTL, 64'h3);
        rd(A_CTL, d); chk("R9 released", d, 64'h3);
        br(64'hEE, 64'hFF, 1'b1, 3'd4, 1'b0);
        check_all("R9 after release");

        // R10: clear versus branch in same cycle
        step(1'b1, 64'h99, 64'h98, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1, A_CTL, 64'h9);
        check_all("R10 clear");
        rd(A_CTL, d); chk("R10 clear bit reads 0", d, 64'h1);

        // Random phase
        for (int n = 0; n < 1500; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3)
                wr(A_SEL, AW'($urandom_range(0, 15) == 0 ? 32'h0 : ($urandom & 32'h1FF)));
            else if (r < 5)
                wr(A_CTL, AW'($urandom_range(0, 7)) | (($urandom_range(0, 9) == 0) ? 64'h8 : 64'h0));
            else
                step($urandom_range(0, 3) != 0, rnd64(), rnd64(), 1'($urandom), 3'($urandom),
                     1'($urandom), $urandom_range(0, 49) == 0, 1'b0, 12'h0, '0);
            if (n % 100 == 99) check_all("R2 R4 R5 R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule